// File: doc/BRIEF.md
# Request Acknowledgement Watchdog

This block is the requester side of a stop-and-wait message exchange. A local client offers a request carrying one of three message types; when the block is idle it issues that request to the peer as a one-cycle transmit strobe and then holds off any further request until the exchange closes. The exchange closes when the peer acknowledges or when a watchdog expires.

The watchdog is a single counter shared by all three message types. It counts pulses of a once-per-millisecond tick while a request is pending. The limit is read from a configuration input at the moment the request is issued, clamped to the range 1 to 3. When the limit is reached without an acknowledgement, the block emits a one-cycle timeout pulse. It also records which message type expired. An acknowledgement that arrives with nothing pending is dropped and noted in a sticky status flag.

Top module: `req_ack_timer`

## Requirements
- R1: After reset, `pending`, `timeout`, `tmo_type_vld` and `unexp_ack` are 0 and `req_ready` is 1.
- R2: `req_ready` equals the inverse of `pending`. `tx_strobe` is high in exactly the cycles where `req_valid` and `req_ready` are both high, with `tx_type` equal to `req_type`. `pending` is 1 from the following cycle on. While `pending` is 1, no strobe is issued.
- R3: The watchdog limit in milliseconds is `tmo_cfg` clamped to 1..3, so 0 maps to 1 and values above 3 map to 3. It is sampled in the issuing cycle, and later changes to `tmo_cfg` do not affect the pending request.
- R4: Ticks are counted only in cycles where `pending` is 1. The cycle after the clock edge that sees the limit-th counted tick, `timeout` is 1 for exactly one cycle and `pending` is 0. The timer behaves the same for all three types (codes 0, 1, 2).
- R5: On timeout, `tmo_type` takes the expired request's type and `tmo_type_vld` becomes 1. `tmo_type_vld` returns to 0 the cycle after the next request is issued.
- R6: `ack_in` while `pending` clears `pending` on the next cycle with no timeout. This also holds when the acknowledgement arrives in the same cycle as the limit-th tick.
- R7: `ack_in` while `pending` is 0 changes nothing except to set `unexp_ack`, which stays 1 until reset. An acknowledgement of a pending request does not set it.
- R8: After any number of earlier timeouts, each new request restarts the count from zero and expires after its full limit.
- R9: A reset applied while a request is pending restores the R1 state. The next request then takes its full limit to expire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client offers a request |
| req_type | input | TYPE_W | Message type of the offered request (0, 1 or 2) |
| req_ready | output | 1 | Block can accept a request |
| tx_strobe | output | 1 | Request issued to the peer this cycle |
| tx_type | output | TYPE_W | Type of the issued request |
| ack_in | input | 1 | Acknowledgement from the peer |
| tmo_cfg | input | CFG_W | Watchdog limit in milliseconds, clamped to 1..3 |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pending | output | 1 | A request is outstanding |
| timeout | output | 1 | One-cycle pulse on watchdog expiry |
| tmo_type | output | TYPE_W | Type of the last expired request |
| tmo_type_vld | output | 1 | `tmo_type` is current |
| unexp_ack | output | 1 | Sticky flag: an acknowledgement arrived while idle |

## Verification
The bench sweeps every configuration code against all three types. An off-by-one counter would fire a tick early or late, and a missing clamp would hang or fire at once for codes 0 and 4 to 7. Changing the configuration mid-request exposes a limit that is read live rather than latched. An acknowledgement placed on the terminal tick catches a design that lets the timeout win the collision. A reset during a count, followed by a full-length request, catches a counter or limit that survives reset and would expire early.

// File: rtl/req_ack_timer.sv
module req_ack_timer #(
  parameter int TYPE_W = 2,
  parameter int CFG_W  = 3,
  parameter int MIN_MS = 1,
  parameter int MAX_MS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [TYPE_W-1:0] req_type,
  output logic              req_ready,
  output logic              tx_strobe,
  output logic [TYPE_W-1:0] tx_type,
  input  logic              ack_in,
  input  logic [CFG_W-1:0]  tmo_cfg,
  input  logic              ms_tick,
  output logic              pending,
  output logic              timeout,
  output logic [TYPE_W-1:0] tmo_type,
  output logic              tmo_type_vld,
  output logic              unexp_ack
);
  localparam int CNT_W = $clog2(MAX_MS + 1);

  logic [CNT_W-1:0]  cnt, cnt_inc, lim_q, lim_c;
  logic [TYPE_W-1:0] cur_type;

  assign req_ready = !pending;
  assign tx_strobe = req_valid && !pending;
  assign tx_type   = req_type;
  assign cnt_inc   = cnt + CNT_W'(1);

  always_comb begin
    if (int'(tmo_cfg) < MIN_MS)      lim_c = CNT_W'(MIN_MS);
    else if (int'(tmo_cfg) > MAX_MS) lim_c = CNT_W'(MAX_MS);
    else                             lim_c = CNT_W'(tmo_cfg);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending      <= 1'b0;
      cnt          <= '0;
      lim_q        <= '0;
      cur_type     <= '0;
      timeout      <= 1'b0;
      tmo_type     <= '0;
      tmo_type_vld <= 1'b0;
      unexp_ack    <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (tx_strobe) begin
        pending      <= 1'b1;
        cnt          <= '0;
        lim_q        <= lim_c;
        cur_type     <= req_type;
        tmo_type_vld <= 1'b0;
      end else if (pending) begin
        if (ack_in) begin
          pending <= 1'b0;
        end else if (ms_tick) begin
          if (cnt_inc == lim_q) begin
            pending      <= 1'b0;
            timeout      <= 1'b1;
            tmo_type     <= cur_type;
            tmo_type_vld <= 1'b1;
          end else begin
            cnt <= cnt_inc;
          end
        end
      end
      if (ack_in && !pending) unexp_ack <= 1'b1;
    end
  end
endmodule

// File: rtl/req_ack_timer_chk.sv
module req_ack_timer_chk #(
  parameter int TYPE_W = 2,
  parameter int CFG_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [TYPE_W-1:0] req_type,
  input logic              req_ready,
  input logic              tx_strobe,
  input logic [TYPE_W-1:0] tx_type,
  input logic              ack_in,
  input logic [CFG_W-1:0]  tmo_cfg,
  input logic              ms_tick,
  input logic              pending,
  input logic              timeout,
  input logic [TYPE_W-1:0] tmo_type,
  input logic              tmo_type_vld,
  input logic              unexp_ack
);
  a_r2_issue_then_pending: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |=> pending);
  a_r2_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !tx_strobe);
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
  a_r4_timeout_closes: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !pending);
  a_r5_type_latched: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> tmo_type_vld);
  a_r6_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && ack_in) |=> (!pending && !timeout));
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    unexp_ack |=> unexp_ack);
endmodule

bind req_ack_timer req_ack_timer_chk #(.TYPE_W(TYPE_W), .CFG_W(CFG_W)) u_chk (.*);

// File: tb/test_req_ack_timer.sv
module test_req_ack_timer;
  logic       clk = 0, rst_n = 0;
  logic       req_valid = 0, ack_in = 0, ms_tick = 0;
  logic [1:0] req_type = 0;
  logic [2:0] tmo_cfg = 0;
  logic       req_ready, tx_strobe, pending, timeout, tmo_type_vld, unexp_ack;
  logic [1:0] tx_type, tmo_type;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  req_ack_timer i_req_ack_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_ready(req_ready), .tx_strobe(tx_strobe), .tx_type(tx_type),
    .ack_in(ack_in), .tmo_cfg(tmo_cfg), .ms_tick(ms_tick), .pending(pending),
    .timeout(timeout), .tmo_type(tmo_type), .tmo_type_vld(tmo_type_vld),
    .unexp_ack(unexp_ack));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_reset_state(string req);
    chk({req, " pending"}, pending, 0);
    chk({req, " ready"}, req_ready, 1);
    chk({req, " timeout"}, timeout, 0);
    chk({req, " tmo_type_vld"}, tmo_type_vld, 0);
    chk({req, " unexp_ack"}, unexp_ack, 0);
  endtask

  function automatic int clamp(int c);
    return c < 1 ? 1 : (c > 3 ? 3 : c);
  endfunction

  task automatic send(int t);
    @(negedge clk);
    req_valid = 1; req_type = 2'(t);
    #1;
    chk("R2 strobe", tx_strobe, 1);
    chk("R2 tx_type", tx_type, t);
    @(negedge clk);
    req_valid = 0;
    chk("R2 pending", pending, 1);
    chk("R2 ready low", req_ready, 0);
    chk("R5 vld cleared", tmo_type_vld, 0);
  endtask

  task automatic cyc(bit tk, bit ak);
    ms_tick = tk; ack_in = ak;
    @(negedge clk);
    ms_tick = 0; ack_in = 0;
  endtask

  task automatic run_timeout(int t, int lim, string req);
    for (int i = 1; i <= lim; i++) begin
      cyc(0, 0);
      cyc(1, 0);
      if (i < lim) begin
        chk({req, " still pending"}, pending, 1);
        chk({req, " no early timeout"}, timeout, 0);
      end else begin
        chk({req, " timeout"}, timeout, 1);
        chk({req, " pending clear"}, pending, 0);
        chk("R5 tmo_type", tmo_type, t);
        chk("R5 tmo_type_vld", tmo_type_vld, 1);
      end
    end
    cyc(0, 0);
    chk("R4 single pulse", timeout, 0);
    chk("R5 vld held", tmo_type_vld, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_state("R1");
    rst_n = 1;
    @(negedge clk);
    chk_reset_state("R1");

    // R3 R4 R8: every config code against every type, repeated timeouts
    for (int c = 0; c < 8; c++) begin
      for (int t = 0; t < 3; t++) begin
        tmo_cfg = 3'(c);
        send(t);
        tmo_cfg = 3'(c ^ 7);
        run_timeout(t, clamp(c), "R3 R4 R8");
      end
    end

    // R6: ack before the limit and ack colliding with the terminal tick
    for (int lim = 1; lim <= 3; lim++) begin
      for (int k = 0; k < lim; k++) begin
        for (int col = 0; col < 2; col++) begin
          if (col == 1 && k != lim - 1) continue;
          tmo_cfg = 3'(lim);
          send(k % 3);
          for (int i = 0; i < k; i++) cyc(1, 0);
          chk("R6 pending before ack", pending, 1);
          cyc(col == 1, 1);
          chk("R6 pending after ack", pending, 0);
          chk("R6 no timeout", timeout, 0);
          cyc(1, 0);
          chk("R6 no late timeout", timeout, 0);
          chk("R6 no tmo vld", tmo_type_vld, 0);
        end
      end
    end
    chk("R7 no flag on valid ack", unexp_ack, 0);

    // R2: requests refused while pending
    tmo_cfg = 3;
    send(1);
    req_valid = 1; req_type = 2;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R2 no strobe while pending", tx_strobe, 0);
      chk("R2 ready low while pending", req_ready, 0);
      @(negedge clk);
    end
    req_valid = 0;
    cyc(0, 1);
    chk("R2 closed by ack", pending, 0);

    // R7: idle ack
    cyc(0, 1);
    chk("R7 unexp set", unexp_ack, 1);
    chk("R7 pending unchanged", pending, 0);
    chk("R7 no timeout", timeout, 0);
    chk("R7 ready unchanged", req_ready, 1);
    repeat (4) cyc(1, 0);
    chk("R7 sticky", unexp_ack, 1);

    // R9: reset mid-count, then full-length request
    tmo_cfg = 3;
    send(2);
    cyc(1, 0);
    cyc(1, 0);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    chk_reset_state("R9");
    @(negedge clk);
    chk_reset_state("R9");
    send(0);
    run_timeout(0, 3, "R9");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule